// File: doc/BRIEF.md
# Machine-Mode Trap and Return Controller

This block handles trap entry and trap return for a core that runs in two privilege levels, machine and user. Each cycle it looks at four possible sources of a control transfer: an explicit synchronous exception request carrying a cause code and an optional trap value, a memory access whose address is not a multiple of its width, an environment call, and a return from machine mode. It chooses at most one of them, updates its privilege and status state, and reports the program counter the core should fetch from next.

The controller holds the current privilege, the interrupt-enable bit, the saved interrupt-enable bit, the saved previous privilege, the exception PC, the cause and the trap value. The trap vector is a fixed design parameter. A request that names a cause the controller does not accept, or that omits the trap value where one is needed, is reported on an internal-error output and leaves all state untouched. Instruction decode, register-access instructions, interrupts and the memory access itself belong to other blocks.

Top module: `trapc_top`

## Requirements
- R1: After a synchronous reset the privilege reads 2'b11 (machine), the interrupt enable and saved enable read 0, the saved privilege reads 2'b00 (user), the exception PC, cause and trap value read 0, and `redirect` and `int_err` are low.
- R2: When a trap is taken, in the same cycle `redirect` is high and `next_pc` equals the trap vector; on the following edge the exception PC takes `cur_pc`, the saved enable takes the enable, the enable clears, the saved privilege takes the privilege, the privilege becomes machine (2'b11) and the cause register takes the trap cause.
- R3: An environment call traps with cause 8 when the privilege is user and cause 11 when it is machine, and leaves the trap-value register unchanged.
- R4: An exception request whose cause is one of 0, 1, 2, 4, 5, 6, 7, 12, 13 or 15 and whose trap value is marked valid traps with that cause and loads the trap-value register with the supplied value.
- R5: An exception request whose cause is outside that set, or whose cause is in the set but whose trap value is not marked valid, raises `int_err` in that cycle, keeps `redirect` low, gives `next_pc` equal to `cur_pc`, and changes no state.
- R6: A memory access of 2^`mem_size` bytes whose address is not a multiple of that width traps with cause 4 for a load or 6 for a store, and the trap value takes the address; an aligned access causes no trap.
- R7: A machine return drives `redirect` high with `next_pc` equal to the exception PC, and on the next edge the enable takes the saved enable, the saved enable becomes 1 and the privilege takes the saved privilege.
- R8: When several sources are active in one cycle, the exception request wins over a misaligned access, which wins over an environment call, which wins over a machine return.
- R9: With no source active, `redirect` and `int_err` are low, `next_pc` is `cur_pc` + 4 and no state changes.
- R10: An illegal-instruction exception (cause 2) with a valid trap value of zero, as raised for the all-zero compressed word, writes zero into the trap-value register even when it held a non-zero value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cur_pc | input | XLEN | PC of the instruction in this cycle |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | 4 | Cause code of the exception request |
| exc_tval_vld | input | 1 | Trap value of the request is supplied |
| exc_tval | input | XLEN | Trap value of the request |
| mem_req | input | 1 | Memory access under alignment check |
| mem_store | input | 1 | Access is a store (1) or a load (0) |
| mem_size | input | 2 | Access width as log2 of the byte count |
| mem_addr | input | XLEN | Access address |
| ecall_req | input | 1 | Environment call |
| mret_req | input | 1 | Return from machine mode |
| next_pc | output | XLEN | PC to fetch next |
| redirect | output | 1 | A trap or return is taken this cycle |
| int_err | output | 1 | Request rejected as an internal error |
| priv | output | 2 | Current privilege, 2'b00 user, 2'b11 machine |
| mie | output | 1 | Interrupt enable |
| mpie | output | 1 | Saved interrupt enable |
| mpp | output | 2 | Saved privilege |
| epc | output | XLEN | Exception PC |
| cause | output | 4 | Last trap cause |
| tval | output | XLEN | Trap value |

## Verification
The assertions take for granted that `cur_pc` is a multiple of four and that the saved privilege only ever holds a value the controller itself wrote, so the privilege stays at user or machine; they do not constrain how many request lines are high in one cycle. The stimulus keeps `cur_pc` word aligned and uses every `mem_size` value, while it deliberately raises several request lines together and draws exception causes from all sixteen codes so that the priority order and the rejected cases are reached as well as the accepted ones.

// File: rtl/trapc_pkg.sv
// Shared definitions of the trap controller: privilege encoding, event
// kinds and cause codes. Assumes a 4-bit cause field.
package trapc_pkg;

    localparam int CAUSE_W = 4;

    typedef enum logic [1:0] {
        PRIV_USER = 2'b00,
        PRIV_MACH = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_TRAP = 2'd1,
        EV_MRET = 2'd2,
        EV_ERR  = 2'd3
    } ev_e;

    localparam logic [CAUSE_W-1:0] CS_FETCH_MIS = 4'd0;
    localparam logic [CAUSE_W-1:0] CS_FETCH_ACC = 4'd1;
    localparam logic [CAUSE_W-1:0] CS_ILLEGAL   = 4'd2;
    localparam logic [CAUSE_W-1:0] CS_LOAD_MIS  = 4'd4;
    localparam logic [CAUSE_W-1:0] CS_LOAD_ACC  = 4'd5;
    localparam logic [CAUSE_W-1:0] CS_STORE_MIS = 4'd6;
    localparam logic [CAUSE_W-1:0] CS_STORE_ACC = 4'd7;
    localparam logic [CAUSE_W-1:0] CS_CALL_USER = 4'd8;
    localparam logic [CAUSE_W-1:0] CS_CALL_MACH = 4'd11;
    localparam logic [CAUSE_W-1:0] CS_FETCH_PF  = 4'd12;
    localparam logic [CAUSE_W-1:0] CS_LOAD_PF   = 4'd13;
    localparam logic [CAUSE_W-1:0] CS_STORE_PF  = 4'd15;

    // True for the causes that an exception request may raise; each of
    // them carries a trap value.
    function automatic logic cause_takes_tval(input logic [CAUSE_W-1:0] c);
        case (c)
            CS_FETCH_MIS, CS_FETCH_ACC, CS_ILLEGAL,
            CS_LOAD_MIS,  CS_LOAD_ACC,  CS_STORE_MIS, CS_STORE_ACC,
            CS_FETCH_PF,  CS_LOAD_PF,   CS_STORE_PF:  return 1'b1;
            default:                                   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/trapc_misalign.sv
// Alignment checker: flags a memory access whose address is not a
// multiple of its width (2**mem_size bytes) and names the matching cause.
// Assumes mem_size never exceeds 2**SIZE_W - 1.
module trapc_misalign
    import trapc_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int SIZE_W = 2
) (
    input  logic                mem_req,
    input  logic                mem_store,
    input  logic [SIZE_W-1:0]   mem_size,
    input  logic [XLEN-1:0]     mem_addr,
    output logic                mis_hit,
    output logic [CAUSE_W-1:0]  mis_cause
);
    localparam int OFS_W = (2 ** SIZE_W) - 1;

    logic [OFS_W-1:0] ofs_mask;

    // One mask bit per low address bit that must be zero for this width.
    for (genvar gi = 0; gi < OFS_W; gi++) begin : g_mask
        assign ofs_mask[gi] = (int'(mem_size) > gi);
    end

    // Misaligned when any masked low address bit is set.
    always_comb begin
        mis_hit   = mem_req && ((mem_addr[OFS_W-1:0] & ofs_mask) != '0);
        mis_cause = mem_store ? CS_STORE_MIS : CS_LOAD_MIS;
    end

endmodule

// File: rtl/trapc_select.sv
// Event selector: picks one control transfer per cycle in the fixed order
// exception request, misaligned access, environment call, machine return,
// and classifies rejected exception requests as internal errors.
// Purely combinational.
module trapc_select
    import trapc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  priv_e               priv_q,
    input  logic                exc_req,
    input  logic [CAUSE_W-1:0]  exc_cause,
    input  logic                exc_tval_vld,
    input  logic [XLEN-1:0]     exc_tval,
    input  logic                mis_hit,
    input  logic [CAUSE_W-1:0]  mis_cause,
    input  logic [XLEN-1:0]     mem_addr,
    input  logic                ecall_req,
    input  logic                mret_req,
    output ev_e                 ev_kind,
    output logic [CAUSE_W-1:0]  ev_cause,
    output logic [XLEN-1:0]     ev_tval,
    output logic                ev_tval_we
);
    // Priority chain that resolves the cycle's single event.
    always_comb begin
        ev_kind    = EV_NONE;
        ev_cause   = '0;
        ev_tval    = '0;
        ev_tval_we = 1'b0;
        if (exc_req) begin
            if (cause_takes_tval(exc_cause) && exc_tval_vld) begin
                ev_kind    = EV_TRAP;
                ev_cause   = exc_cause;
                ev_tval    = exc_tval;
                ev_tval_we = 1'b1;
            end else begin
                ev_kind = EV_ERR;
            end
        end else if (mis_hit) begin
            ev_kind    = EV_TRAP;
            ev_cause   = mis_cause;
            ev_tval    = mem_addr;
            ev_tval_we = 1'b1;
        end else if (ecall_req) begin
            ev_kind  = EV_TRAP;
            ev_cause = (priv_q == PRIV_USER) ? CS_CALL_USER : CS_CALL_MACH;
        end else if (mret_req) begin
            ev_kind = EV_MRET;
        end
    end

endmodule

// File: rtl/trapc_state.sv
// Privilege and trap state: current privilege, enable / saved enable,
// saved privilege, exception PC, cause and trap value. Applies the event
// chosen by the selector on each edge. Assumes saved privilege is only
// written from the current privilege.
module trapc_state
    import trapc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  ev_e                 ev_kind,
    input  logic [CAUSE_W-1:0]  ev_cause,
    input  logic [XLEN-1:0]     ev_tval,
    input  logic                ev_tval_we,
    input  logic [XLEN-1:0]     cur_pc,
    output priv_e               priv_q,
    output logic                mie_q,
    output logic                mpie_q,
    output priv_e               mpp_q,
    output logic [XLEN-1:0]     epc_q,
    output logic [CAUSE_W-1:0]  cause_q,
    output logic [XLEN-1:0]     tval_q
);
    // Trap entry stacks the state, return pops it, anything else holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q  <= PRIV_MACH;
            mie_q   <= 1'b0;
            mpie_q  <= 1'b0;
            mpp_q   <= PRIV_USER;
            epc_q   <= '0;
            cause_q <= '0;
            tval_q  <= '0;
        end else begin
            case (ev_kind)
                EV_TRAP: begin
                    epc_q   <= cur_pc;
                    cause_q <= ev_cause;
                    mpie_q  <= mie_q;
                    mie_q   <= 1'b0;
                    mpp_q   <= priv_q;
                    priv_q  <= PRIV_MACH;
                    if (ev_tval_we) begin
                        tval_q <= ev_tval;
                    end
                end
                EV_MRET: begin
                    mie_q  <= mpie_q;
                    mpie_q <= 1'b1;
                    priv_q <= mpp_q;
                end
                default: begin
                end
            endcase
        end
    end

    AST_TRAP_TO_MACHINE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_kind == EV_TRAP |=> (priv_q == PRIV_MACH) && !mie_q);  // R2
    AST_TRAP_STACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_kind == EV_TRAP |=> (mpie_q == $past(mie_q)) && (mpp_q == $past(priv_q))
                               && (epc_q == $past(cur_pc)));  // R2
    AST_MRET_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_kind == EV_MRET |=> (mie_q == $past(mpie_q)) && mpie_q
                               && (priv_q == $past(mpp_q)));  // R7
    AST_ERR_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_kind == EV_ERR |=> $stable(epc_q) && $stable(tval_q) && $stable(cause_q)
                              && $stable(priv_q) && $stable(mie_q));  // R5
    AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_q == PRIV_USER) || (priv_q == PRIV_MACH));  // R2

endmodule

// File: rtl/trapc_top.sv
// Trap and return controller top: checks alignment, selects the cycle's
// event, updates privilege/trap state and forms the next PC. The trap
// vector is fixed by TRAP_VEC. Assumes cur_pc is word aligned.
module trapc_top
    import trapc_pkg::*;
#(
    parameter int              XLEN     = 64,
    parameter int              SIZE_W   = 2,
    parameter int              ILEN_B   = 4,
    parameter logic [XLEN-1:0] TRAP_VEC = 64'h0000_0000_8000_0100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic                exc_req,
    input  logic [3:0]          exc_cause,
    input  logic                exc_tval_vld,
    input  logic [XLEN-1:0]     exc_tval,
    input  logic                mem_req,
    input  logic                mem_store,
    input  logic [SIZE_W-1:0]   mem_size,
    input  logic [XLEN-1:0]     mem_addr,
    input  logic                ecall_req,
    input  logic                mret_req,
    output logic [XLEN-1:0]     next_pc,
    output logic                redirect,
    output logic                int_err,
    output logic [1:0]          priv,
    output logic                mie,
    output logic                mpie,
    output logic [1:0]          mpp,
    output logic [XLEN-1:0]     epc,
    output logic [3:0]          cause,
    output logic [XLEN-1:0]     tval
);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(ILEN_B);

    logic                mis_hit;
    logic [CAUSE_W-1:0]  mis_cause;
    ev_e                 ev_kind;
    logic [CAUSE_W-1:0]  ev_cause;
    logic [XLEN-1:0]     ev_tval;
    logic                ev_tval_we;
    priv_e               priv_q;
    priv_e               mpp_q;

    trapc_misalign #(.XLEN(XLEN), .SIZE_W(SIZE_W)) u_mis (
        .mem_req   (mem_req),
        .mem_store (mem_store),
        .mem_size  (mem_size),
        .mem_addr  (mem_addr),
        .mis_hit   (mis_hit),
        .mis_cause (mis_cause)
    );

    trapc_select #(.XLEN(XLEN)) u_sel (
        .priv_q       (priv_q),
        .exc_req      (exc_req),
        .exc_cause    (exc_cause),
        .exc_tval_vld (exc_tval_vld),
        .exc_tval     (exc_tval),
        .mis_hit      (mis_hit),
        .mis_cause    (mis_cause),
        .mem_addr     (mem_addr),
        .ecall_req    (ecall_req),
        .mret_req     (mret_req),
        .ev_kind      (ev_kind),
        .ev_cause     (ev_cause),
        .ev_tval      (ev_tval),
        .ev_tval_we   (ev_tval_we)
    );

    trapc_state #(.XLEN(XLEN)) u_st (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_kind    (ev_kind),
        .ev_cause   (ev_cause),
        .ev_tval    (ev_tval),
        .ev_tval_we (ev_tval_we),
        .cur_pc     (cur_pc),
        .priv_q     (priv_q),
        .mie_q      (mie),
        .mpie_q     (mpie),
        .mpp_q      (mpp_q),
        .epc_q      (epc),
        .cause_q    (cause),
        .tval_q     (tval)
    );

    assign priv = priv_q;
    assign mpp  = mpp_q;

    // Next-PC selection from the resolved event.
    always_comb begin
        redirect = 1'b0;
        int_err  = 1'b0;
        case (ev_kind)
            EV_TRAP: begin
                next_pc  = TRAP_VEC;
                redirect = 1'b1;
            end
            EV_MRET: begin
                next_pc  = epc;
                redirect = 1'b1;
            end
            EV_ERR: begin
                next_pc = cur_pc;
                int_err = 1'b1;
            end
            default: next_pc = cur_pc + PC_STEP;
        endcase
    end

    AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !exc_req && mem_size == '0 && ecall_req)
            |-> (cause_takes_tval(ev_cause) == 1'b0) && redirect);  // R6
    AST_ECALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ecall_req && !exc_req && !mem_req)
            |=> (cause == ($past(priv) == 2'b00 ? 4'd8 : 4'd11)) && (priv == 2'b11));  // R3
    AST_EXC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (redirect || int_err) && !(redirect && int_err));  // R8
    AST_TVAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_tval_vld && cause_takes_tval(exc_cause))
            |=> tval == $past(exc_tval));  // R4

endmodule

// File: tb/tb_trapc_top.sv
// Bench for trapc_top: a behavioural reference model is stepped alongside
// the design and every output is compared each cycle.
module tb_trapc_top;
    localparam logic [63:0] VEC = 64'h0000_0000_8000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cur_pc = '0;
    logic        exc_req = 1'b0;
    logic [3:0]  exc_cause = '0;
    logic        exc_tval_vld = 1'b0;
    logic [63:0] exc_tval = '0;
    logic        mem_req = 1'b0;
    logic        mem_store = 1'b0;
    logic [1:0]  mem_size = '0;
    logic [63:0] mem_addr = '0;
    logic        ecall_req = 1'b0;
    logic        mret_req = 1'b0;
    logic [63:0] next_pc, epc, tval;
    logic        redirect, int_err, mie, mpie;
    logic [1:0]  priv, mpp;
    logic [3:0]  cause;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [1:0]  m_priv = 2'b11, m_mpp = 2'b00;
    logic        m_mie = 0, m_mpie = 0;
    logic [63:0] m_epc = 0, m_tval = 0;
    logic [3:0]  m_cause = 0;

    trapc_top #(.TRAP_VEC(VEC)) dut (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .exc_req(exc_req),
        .exc_cause(exc_cause), .exc_tval_vld(exc_tval_vld), .exc_tval(exc_tval),
        .mem_req(mem_req), .mem_store(mem_store), .mem_size(mem_size),
        .mem_addr(mem_addr), .ecall_req(ecall_req), .mret_req(mret_req),
        .next_pc(next_pc), .redirect(redirect), .int_err(int_err), .priv(priv),
        .mie(mie), .mpie(mpie), .mpp(mpp), .epc(epc), .cause(cause), .tval(tval)
    );

    always #2 clk = ~clk;  // 250 MHz

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk(tag, "priv", 64'(priv), 64'(m_priv));
        chk(tag, "mie", 64'(mie), 64'(m_mie));
        chk(tag, "mpie", 64'(mpie), 64'(m_mpie));
        chk(tag, "mpp", 64'(mpp), 64'(m_mpp));
        chk(tag, "epc", epc, m_epc);
        chk(tag, "cause", 64'(cause), 64'(m_cause));
        chk(tag, "tval", tval, m_tval);
    endtask

    task automatic idle_inputs();
        exc_req = 0; exc_tval_vld = 0; mem_req = 0; ecall_req = 0; mret_req = 0;
    endtask

    function automatic bit accepted(input logic [3:0] c);
        return c inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd12, 4'd13, 4'd15};
    endfunction

    // One cycle: inputs already driven at a falling edge.
    task automatic step(input string tag);
        int kind;            // 0 none, 1 trap, 2 return, 3 error
        logic [3:0] ec;
        logic [63:0] et;
        bit twe;
        longint unsigned w;
        kind = 0; ec = 0; et = 0; twe = 0;
        #1;
        w = longint'(1) << mem_size;
        if (exc_req) begin
            if (accepted(exc_cause) && exc_tval_vld) begin
                kind = 1; ec = exc_cause; et = exc_tval; twe = 1;
            end else kind = 3;
        end else if (mem_req && (mem_addr % w) != 0) begin
            kind = 1; ec = mem_store ? 4'd6 : 4'd4; et = mem_addr; twe = 1;
        end else if (ecall_req) begin
            kind = 1; ec = (m_priv == 2'b00) ? 4'd8 : 4'd11;
        end else if (mret_req) kind = 2;
        case (kind)
            1: begin chk(tag, "next_pc", next_pc, VEC); chk(tag, "redirect", 64'(redirect), 1); end
            2: begin chk(tag, "next_pc", next_pc, m_epc); chk(tag, "redirect", 64'(redirect), 1); end
            3: begin chk(tag, "next_pc", next_pc, cur_pc); chk(tag, "redirect", 64'(redirect), 0); end
            default: begin chk(tag, "next_pc", next_pc, cur_pc + 4); chk(tag, "redirect", 64'(redirect), 0); end
        endcase
        chk(tag, "int_err", 64'(int_err), 64'(kind == 3));
        @(posedge clk);
        if (kind == 1) begin
            m_epc = cur_pc; m_cause = ec; m_mpie = m_mie; m_mie = 0;
            m_mpp = m_priv; m_priv = 2'b11;
            if (twe) m_tval = et;
        end else if (kind == 2) begin
            m_mie = m_mpie; m_mpie = 1; m_priv = m_mpp;
        end
        @(negedge clk);
        chk_state(tag);
        idle_inputs();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R9 actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk_state("R1");
        chk("R1", "redirect", 64'(redirect), 0);
        chk("R1", "int_err", 64'(int_err), 0);

        cur_pc = 64'h1000; step("R9");
        cur_pc = 64'h1004; mret_req = 1; step("R7");          // to user
        chk("R7", "priv_user", 64'(priv), 64'(2'b00));
        cur_pc = 64'h2000; ecall_req = 1; step("R3");         // cause 8
        chk("R3", "cause_user", 64'(cause), 8);
        cur_pc = 64'h2004; ecall_req = 1; step("R3");         // cause 11
        chk("R3", "cause_mach", 64'(cause), 11);
        cur_pc = 64'h2008; mret_req = 1; step("R7");
        cur_pc = 64'h3000; exc_req = 1; exc_cause = 5; exc_tval_vld = 1;
        exc_tval = 64'hDEAD_BEEF; step("R4");
        chk("R4", "tval_load", tval, 64'hDEAD_BEEF);
        cur_pc = 64'h3004; exc_req = 1; exc_cause = 2; exc_tval_vld = 1;
        exc_tval = 0; step("R10");
        chk("R10", "tval_zero", tval, 0);
        cur_pc = 64'h3008; exc_req = 1; exc_cause = 13; exc_tval_vld = 0; step("R5");
        cur_pc = 64'h300C; exc_req = 1; exc_cause = 3; exc_tval_vld = 1; exc_tval = 7; step("R5");
        cur_pc = 64'h3010; exc_req = 1; exc_cause = 11; exc_tval_vld = 1; step("R5");
        cur_pc = 64'h4000; mem_req = 1; mem_store = 0; mem_size = 2; mem_addr = 64'h1002; step("R6");
        chk("R6", "load_mis", 64'(cause), 4);
        cur_pc = 64'h4004; mem_req = 1; mem_store = 1; mem_size = 1; mem_addr = 64'h11; step("R6");
        chk("R6", "store_mis", 64'(cause), 6);
        cur_pc = 64'h4008; mem_req = 1; mem_size = 3; mem_addr = 64'h18; step("R6");
        cur_pc = 64'h400C; mem_req = 1; mem_size = 0; mem_addr = 64'h13; step("R6");
        cur_pc = 64'h5000; exc_req = 1; exc_cause = 1; exc_tval_vld = 1; exc_tval = 64'h55;
        mem_req = 1; mem_size = 3; mem_addr = 64'h3; ecall_req = 1; mret_req = 1; step("R8");
        chk("R8", "exc_wins", 64'(cause), 1);
        cur_pc = 64'h5004; mem_req = 1; mem_store = 1; mem_size = 2; mem_addr = 64'h6;
        ecall_req = 1; mret_req = 1; step("R8");
        chk("R8", "mis_wins", 64'(cause), 6);
        cur_pc = 64'h5008; ecall_req = 1; mret_req = 1; step("R8");
        chk("R8", "ecall_wins", 64'(cause), 11);

        for (int i = 0; i < 600; i++) begin
            cur_pc       = {32'h0, $urandom} & 64'hFFFF_FFFC;
            exc_req      = ($urandom % 6) == 0;
            exc_cause    = 4'($urandom);
            exc_tval_vld = ($urandom % 4) != 0;
            exc_tval     = {$urandom, $urandom};
            mem_req      = ($urandom % 4) == 0;
            mem_store    = 1'($urandom);
            mem_size     = 2'($urandom);
            mem_addr     = {32'h0, $urandom};
            ecall_req    = ($urandom % 5) == 0;
            mret_req     = ($urandom % 4) == 0;
            step("R8");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule